// File: doc/BRIEF.md
# Dual-Channel Memory Address Mapper

This block sits between the system address path and two independent DRAM channels. From a set of configuration inputs describing, for each channel, which module slots are occupied, how large each module is, whether the modules are registered, and the speed each module supports, it checks the population rules. It then chooses how system physical addresses are distributed across the channels.

When both channels are populated with equal capacity, consecutive 64-byte cache lines alternate between the channels. When both are populated with different capacities, the address space is a plain concatenation: channel A first, then channel B. When only one channel is populated, all traffic goes to it. Every accepted request address comes back one clock later as a channel select, a channel-local address and an error flag. The block also reports the operating speed shared by all modules, which is the slowest speed found among the installed modules.

The configuration is captured while a load strobe is high. Requests are refused during the load.

Top module: `dual_chan_mapper`

## Requirements
- R1: The configuration inputs are captured on each clock edge at which `cfg_load` is high, and are ignored otherwise. `req_ready` is low while `cfg_load` is high, so no request is accepted during a load.
- R2: A configuration is invalid (`cfg_ok`=0) when no slot in either channel is occupied, or when a channel has any slot occupied but its slot 0 is empty.
- R3: A channel whose modules are unbuffered (`cfg_rdimm_x`=0) may use only slots 0 and 1, and an occupied slot 2 makes the configuration invalid. A registered channel may use slots 0, 1 and 2.
- R4: `cfg_mode` is 0 (single) when exactly one channel has occupied slots. It is 1 (interleaved) when both channels are occupied with equal total size. It is 2 (concatenated) when both are occupied with different total sizes.
- R5: In interleaved mode, address bit 6 selects the channel (0 = A, 1 = B). The local address is the system address with bit 6 removed: bits 5..0 are kept, and bits above 6 move down by one.
- R6: In concatenated mode, an address below the channel A capacity maps to channel A unchanged. An address at or above it maps to channel B with the channel A capacity subtracted.
- R7: In single mode, `map_chan` names the occupied channel and the local address equals the system address.
- R8: An address at or above the total installed capacity (sum of both channels, sizes in MiB units) sets `map_err`.
- R9: Any request made while the configuration is invalid sets `map_err`. Whenever `map_err` is 1, `map_chan` and `map_addr` are 0.
- R10: `mem_freq` is the minimum speed code among all occupied slots of both channels, or 0 when no slot is occupied.
- R11: `map_valid` is high for exactly one cycle, in the cycle after each accepted request (`req_valid` and `req_ready` both high), and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Configuration capture strobe |
| cfg_pres_a | input | NSLOT | Slot occupancy, channel A (bit i = slot i) |
| cfg_pres_b | input | NSLOT | Slot occupancy, channel B |
| cfg_rdimm_a | input | 1 | Channel A modules are registered |
| cfg_rdimm_b | input | 1 | Channel B modules are registered |
| cfg_size_a | input | NSLOT*SZ_W | Per-slot size in 2^GRAN_SH-byte units, channel A |
| cfg_size_b | input | NSLOT*SZ_W | Per-slot size, channel B |
| cfg_freq_a | input | NSLOT*FQ_W | Per-slot speed code, channel A |
| cfg_freq_b | input | NSLOT*FQ_W | Per-slot speed code, channel B |
| req_valid | input | 1 | Request address valid |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | ADDR_W | System physical address |
| map_valid | output | 1 | Mapped result valid |
| map_chan | output | 1 | Selected channel (0 = A, 1 = B) |
| map_addr | output | ADDR_W | Channel-local address |
| map_err | output | 1 | Invalid configuration or out-of-range address |
| cfg_ok | output | 1 | Captured configuration is valid |
| cfg_mode | output | 2 | Selected mode |
| mem_freq | output | FQ_W | Shared operating speed code |

## Verification
The following properties are checked on every cycle:
- the one-cycle result timing and its pulse shape;
- the zeroed channel and address on any error;
- forced errors while the configuration is invalid;
- the bit-6 channel choice in interleaved mode;
- the side of the channel A boundary in concatenated mode;
- the capacity bound on every successful mapping.

The population rules, the mode decision, the minimum-speed result, the exact local-address arithmetic and the fact that configuration inputs are ignored without the strobe can only be shown by the bench's scenarios. These scenarios include directed boundary addresses around the channel A capacity and the total capacity, and random configurations and addresses checked against a bench model.

// File: rtl/dcm_pkg.sv
package dcm_pkg;
    typedef enum logic [1:0] {
        MODE_SINGLE = 2'd0,
        MODE_ILV    = 2'd1,
        MODE_ASYM   = 2'd2
    } map_mode_e;
endpackage

// File: rtl/dcm_chan_eval.sv
module dcm_chan_eval #(
    parameter int NSLOT       = 3,
    parameter int UNBUF_SLOTS = 2,
    parameter int SZ_W        = 12,
    parameter int FQ_W        = 8,
    parameter int CU_W        = 14
) (
    input  logic [NSLOT-1:0]      pres,
    input  logic                  rdimm,
    input  logic [NSLOT*SZ_W-1:0] size,
    input  logic [NSLOT*FQ_W-1:0] freq,
    output logic                  any,
    output logic                  rules_ok,
    output logic [CU_W-1:0]       cap_units,
    output logic [FQ_W-1:0]       fmin
);
    always_comb begin
        cap_units = '0;
        fmin      = '1;
        any       = |pres;
        rules_ok  = 1'b1;
        for (int i = 0; i < NSLOT; i++) begin
            if (pres[i]) begin
                cap_units = cap_units + CU_W'(size[i*SZ_W +: SZ_W]);
                if (freq[i*FQ_W +: FQ_W] < fmin) fmin = freq[i*FQ_W +: FQ_W];
                if (!rdimm && i >= UNBUF_SLOTS) rules_ok = 1'b0;
            end
        end
        if (any && !pres[0]) rules_ok = 1'b0;
    end
endmodule

// File: rtl/dcm_xlate.sv
module dcm_xlate
    import dcm_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int CAPB_W  = 35,
    parameter int ILV_BIT = 6
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              cfg_ok,
    input  map_mode_e         mode,
    input  logic              single_b,
    input  logic [CAPB_W-1:0] capa,
    input  logic [CAPB_W-1:0] total,
    output logic              chan,
    output logic [ADDR_W-1:0] laddr,
    output logic              err
);
    localparam logic [ADDR_W-1:0] LOW_MASK = (ADDR_W'(1) << ILV_BIT) - ADDR_W'(1);

    logic [CAPB_W-1:0] a_ext;
    logic [CAPB_W-1:0] diff;

    always_comb begin
        a_ext = CAPB_W'(addr);
        diff  = a_ext - capa;
        chan  = 1'b0;
        laddr = '0;
        err   = 1'b1;
        if (cfg_ok && a_ext < total) begin
            err = 1'b0;
            case (mode)
                MODE_SINGLE: begin
                    chan  = single_b;
                    laddr = addr;
                end
                MODE_ILV: begin
                    chan  = addr[ILV_BIT];
                    laddr = ((addr >> (ILV_BIT + 1)) << ILV_BIT) | (addr & LOW_MASK);
                end
                MODE_ASYM: begin
                    if (a_ext < capa) begin
                        laddr = addr;
                    end else begin
                        chan  = 1'b1;
                        laddr = diff[ADDR_W-1:0];
                    end
                end
                default: err = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/dual_chan_mapper.sv
module dual_chan_mapper
    import dcm_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int NSLOT       = 3,
    parameter int UNBUF_SLOTS = 2,
    parameter int SZ_W        = 12,
    parameter int FQ_W        = 8,
    parameter int GRAN_SH     = 20,
    parameter int LINE_BYTES  = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_load,
    input  logic [NSLOT-1:0]      cfg_pres_a,
    input  logic [NSLOT-1:0]      cfg_pres_b,
    input  logic                  cfg_rdimm_a,
    input  logic                  cfg_rdimm_b,
    input  logic [NSLOT*SZ_W-1:0] cfg_size_a,
    input  logic [NSLOT*SZ_W-1:0] cfg_size_b,
    input  logic [NSLOT*FQ_W-1:0] cfg_freq_a,
    input  logic [NSLOT*FQ_W-1:0] cfg_freq_b,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [ADDR_W-1:0]     req_addr,
    output logic                  map_valid,
    output logic                  map_chan,
    output logic [ADDR_W-1:0]     map_addr,
    output logic                  map_err,
    output logic                  cfg_ok,
    output logic [1:0]            cfg_mode,
    output logic [FQ_W-1:0]       mem_freq
);
    localparam int CU_W    = SZ_W + $clog2(NSLOT + 1);
    localparam int CB_RAW  = CU_W + 1 + GRAN_SH;
    localparam int CAPB_W  = (CB_RAW > ADDR_W + 1) ? CB_RAW : ADDR_W + 1;
    localparam int ILV_BIT = $clog2(LINE_BYTES);

    typedef struct packed {
        logic              ok;
        map_mode_e         mode;
        logic              single_b;
        logic [CAPB_W-1:0] capa;
        logic [CAPB_W-1:0] total;
        logic [FQ_W-1:0]   freq;
        logic              mvalid;
        logic              mchan;
        logic [ADDR_W-1:0] maddr;
        logic              merr;
    } state_t;

    state_t st_d, st_q;

    logic [1:0][NSLOT-1:0]      pres_v;
    logic [1:0]                 rdimm_v;
    logic [1:0][NSLOT*SZ_W-1:0] size_v;
    logic [1:0][NSLOT*FQ_W-1:0] freq_v;
    logic [1:0]                 any_v, rok_v;
    logic [1:0][CU_W-1:0]       cu_v;
    logic [1:0][FQ_W-1:0]       fmin_v;

    assign pres_v  = {cfg_pres_b, cfg_pres_a};
    assign rdimm_v = {cfg_rdimm_b, cfg_rdimm_a};
    assign size_v  = {cfg_size_b, cfg_size_a};
    assign freq_v  = {cfg_freq_b, cfg_freq_a};

    for (genvar ch = 0; ch < 2; ch++) begin : g_chan
        dcm_chan_eval #(
            .NSLOT(NSLOT), .UNBUF_SLOTS(UNBUF_SLOTS),
            .SZ_W(SZ_W), .FQ_W(FQ_W), .CU_W(CU_W)
        ) u_eval (
            .pres(pres_v[ch]), .rdimm(rdimm_v[ch]),
            .size(size_v[ch]), .freq(freq_v[ch]),
            .any(any_v[ch]), .rules_ok(rok_v[ch]),
            .cap_units(cu_v[ch]), .fmin(fmin_v[ch])
        );
    end

    logic              x_chan, x_err;
    logic [ADDR_W-1:0] x_addr;

    dcm_xlate #(.ADDR_W(ADDR_W), .CAPB_W(CAPB_W), .ILV_BIT(ILV_BIT)) u_xlate (
        .addr(req_addr), .cfg_ok(st_q.ok), .mode(st_q.mode),
        .single_b(st_q.single_b), .capa(st_q.capa), .total(st_q.total),
        .chan(x_chan), .laddr(x_addr), .err(x_err)
    );

    logic accept;
    assign req_ready = !cfg_load;
    assign accept    = req_valid && req_ready;

    always_comb begin
        st_d        = st_q;
        st_d.mvalid = accept;
        if (accept) begin
            st_d.mchan = x_chan;
            st_d.maddr = x_addr;
            st_d.merr  = x_err;
        end
        if (cfg_load) begin
            st_d.ok       = (any_v[0] || any_v[1]) && rok_v[0] && rok_v[1];
            st_d.single_b = !any_v[0];
            st_d.capa     = CAPB_W'(cu_v[0]) << GRAN_SH;
            st_d.total    = (CAPB_W'(cu_v[0]) + CAPB_W'(cu_v[1])) << GRAN_SH;
            if (any_v[0] && any_v[1])
                st_d.mode = (cu_v[0] == cu_v[1]) ? MODE_ILV : MODE_ASYM;
            else
                st_d.mode = MODE_SINGLE;
            if (!any_v[0] && !any_v[1])
                st_d.freq = '0;
            else if (!any_v[1] || (any_v[0] && fmin_v[0] < fmin_v[1]))
                st_d.freq = fmin_v[0];
            else
                st_d.freq = fmin_v[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mode <= MODE_SINGLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign map_valid = st_q.mvalid;
    assign map_chan  = st_q.mchan;
    assign map_addr  = st_q.maddr;
    assign map_err   = st_q.merr;
    assign cfg_ok    = st_q.ok;
    assign cfg_mode  = st_q.mode;
    assign mem_freq  = st_q.freq;

    AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> map_valid); // R11
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> !map_valid); // R11
    AST_INVALID_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (map_valid && !cfg_ok) |-> map_err); // R9
    AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (map_valid && map_err) |-> (map_chan == 1'b0 && map_addr == '0)); // R9
    AST_ILV_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && cfg_ok && cfg_mode == 2'd1)
        |=> (map_err || map_chan == $past(req_addr[ILV_BIT]))); // R5
    AST_ASYM_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && cfg_ok && cfg_mode == 2'd2)
        |=> (map_err || (map_chan == (CAPB_W'($past(req_addr)) >= st_q.capa)))); // R6
    AST_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready)
        |=> (map_err || CAPB_W'($past(req_addr)) < st_q.total)); // R8
endmodule

// File: tb/dual_chan_mapper_tb.sv
`timescale 1ns/1ps
module dual_chan_mapper_tb;
    localparam int ADDR_W = 32, NSLOT = 3, SZ_W = 12, FQ_W = 8;

    logic clk = 0, rst_n = 0;
    always #2.5 clk = ~clk;

    logic                  cfg_load = 0;
    logic [NSLOT-1:0]      pa = 0, pb = 0;
    logic                  ra = 0, rb = 0;
    logic [NSLOT*SZ_W-1:0] sa = 0, sb = 0;
    logic [NSLOT*FQ_W-1:0] fa = 0, fb = 0;
    logic                  req_valid = 0;
    logic [ADDR_W-1:0]     req_addr = 0;
    logic                  req_ready, map_valid, map_chan, map_err, cfg_ok;
    logic [ADDR_W-1:0]     map_addr;
    logic [1:0]            cfg_mode;
    logic [FQ_W-1:0]       mem_freq;

    dual_chan_mapper u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
        .cfg_pres_a(pa), .cfg_pres_b(pb), .cfg_rdimm_a(ra), .cfg_rdimm_b(rb),
        .cfg_size_a(sa), .cfg_size_b(sb), .cfg_freq_a(fa), .cfg_freq_b(fb),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .map_valid(map_valid), .map_chan(map_chan), .map_addr(map_addr),
        .map_err(map_err), .cfg_ok(cfg_ok), .cfg_mode(cfg_mode), .mem_freq(mem_freq)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // expected configuration from the bench model
    bit     e_ok, e_sb;
    int     e_mode;
    longint e_capa, e_total;
    int     e_freq;

    task automatic check(input bit cond, input string req, input longint act, input longint exp);
        n_chk++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    function automatic bit chan_ok(input logic [NSLOT-1:0] p, input logic r);
        return !((|p) && !p[0]) && (r || !p[2]);
    endfunction

    function automatic longint chan_cap(input logic [NSLOT-1:0] p, input logic [NSLOT*SZ_W-1:0] s);
        longint c = 0;
        for (int i = 0; i < NSLOT; i++) if (p[i]) c += longint'(s[i*SZ_W +: SZ_W]);
        return c << 20;
    endfunction

    task automatic model_cfg();
        int m = 256;
        e_ok    = ((|pa) || (|pb)) && chan_ok(pa, ra) && chan_ok(pb, rb);
        e_capa  = chan_cap(pa, sa);
        e_total = e_capa + chan_cap(pb, sb);
        e_sb    = !(|pa);
        if ((|pa) && (|pb)) e_mode = (e_capa == chan_cap(pb, sb)) ? 1 : 2;
        else e_mode = 0;
        for (int i = 0; i < NSLOT; i++) begin
            if (pa[i] && fa[i*FQ_W +: FQ_W] < m) m = fa[i*FQ_W +: FQ_W];
            if (pb[i] && fb[i*FQ_W +: FQ_W] < m) m = fb[i*FQ_W +: FQ_W];
        end
        e_freq = (m == 256) ? 0 : m;
    endtask

    task automatic load_cfg(input string req);
        @(negedge clk);
        cfg_load = 1;
        #1;
        check(req_ready == 0, "R1 ready low during load", req_ready, 0);
        @(negedge clk);
        cfg_load = 0;
        model_cfg();
        check(cfg_ok == e_ok, {req, " cfg_ok"}, cfg_ok, e_ok);
        if (e_ok) check(cfg_mode == e_mode[1:0], "R4 mode", cfg_mode, e_mode);
        check(mem_freq == e_freq[FQ_W-1:0], "R10 freq", mem_freq, e_freq);
    endtask

    task automatic do_req(input longint a, input string req);
        bit ech; longint ead; bit eer;
        eer = 1; ech = 0; ead = 0;
        if (e_ok && a < e_total) begin
            eer = 0;
            case (e_mode)
                0: begin ech = e_sb; ead = a; end
                1: begin ech = a[6]; ead = ((a >> 7) << 6) | (a & 63); end
                default: if (a < e_capa) ead = a; else begin ech = 1; ead = a - e_capa; end
            endcase
        end
        @(negedge clk);
        req_valid = 1; req_addr = a[ADDR_W-1:0];
        @(negedge clk);
        req_valid = 0;
        check(map_valid == 1, "R11 valid after accept", map_valid, 1);
        check(map_err == eer, {req, " err"}, map_err, eer);
        check(map_chan == ech, {req, " chan"}, map_chan, ech);
        check(map_addr == ead[ADDR_W-1:0], {req, " addr"}, map_addr, ead);
    endtask

    function automatic longint rnd_addr();
        longint lim = e_total + e_total / 4 + 1;
        if (lim > 64'h1_0000_0000) return longint'($urandom);
        return longint'($urandom) % lim;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_up();
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check(cfg_ok == 0 && map_valid == 0 && req_ready == 1, "R1 reset state", {cfg_ok, map_valid, req_ready}, 3'b001);
        rst_n = 1;

        // R2: nothing populated
        load_cfg("R2 empty");
        do_req(64'h100, "R9 invalid cfg");
        // R11: no pulse without request
        @(negedge clk);
        check(map_valid == 0, "R11 single pulse", map_valid, 0);

        // R2: slot 0 missing
        pa = 3'b010; sa = {12'd0, 12'd256, 12'd0}; fa = {8'd0, 8'd40, 8'd0};
        load_cfg("R2 dimm0 missing");

        // R3: unbuffered slot 2 invalid, registered valid
        pa = 3'b111; ra = 0; sa = {12'd128, 12'd256, 12'd512}; fa = {8'd30, 8'd50, 8'd60};
        load_cfg("R3 unbuffered slot2");
        ra = 1;
        load_cfg("R3 registered slot2");

        // R7: single channel B
        pa = 0; pb = 3'b011; rb = 0; sb = {12'd0, 12'd512, 12'd1024}; fb = {8'd0, 8'd70, 8'd55};
        load_cfg("R7 single");
        do_req(e_total - 1, "R8 single last");
        do_req(e_total, "R8 single over");
        for (int i = 0; i < 20; i++) do_req(rnd_addr(), "R7 single rnd");

        // R1: inputs changed without strobe are ignored
        pa = 3'b001; sa = {12'd0, 12'd0, 12'd64}; fa = {8'd0, 8'd0, 8'd10};
        repeat (2) @(negedge clk);
        check(cfg_mode == 2'd0 && mem_freq == 8'd55, "R1 no load ignored", {cfg_mode, mem_freq}, {2'd0, 8'd55});

        // R5: interleave, equal capacity
        pa = 3'b011; ra = 0; sa = {12'd0, 12'd1024, 12'd512}; fa = {8'd0, 8'd66, 8'd48};
        load_cfg("R4 ilv");
        do_req(64'h40, "R5 ilv bit6");
        do_req(64'hFFF_FFBF, "R5 ilv pattern");
        do_req(e_total, "R8 ilv over");
        for (int i = 0; i < 30; i++) do_req(rnd_addr(), "R5 ilv rnd");

        // R6: concatenated, unequal capacity
        sb = {12'd0, 12'd256, 12'd256};
        load_cfg("R4 asym");
        do_req(e_capa - 1, "R6 asym last A");
        do_req(e_capa, "R6 asym first B");
        do_req(e_total - 1, "R6 asym last B");
        do_req(e_total, "R8 asym over");
        for (int i = 0; i < 30; i++) do_req(rnd_addr(), "R6 asym rnd");

        // random configurations
        for (int k = 0; k < 40; k++) begin
            pa = 3'($urandom); pb = 3'($urandom); ra = 1'($urandom); rb = 1'($urandom);
            for (int i = 0; i < NSLOT; i++) begin
                sa[i*SZ_W +: SZ_W] = 12'(1 + $urandom % 512);
                sb[i*SZ_W +: SZ_W] = (k % 4 == 0) ? sa[i*SZ_W +: SZ_W] : 12'(1 + $urandom % 512);
                fa[i*FQ_W +: FQ_W] = 8'($urandom);
                fb[i*FQ_W +: FQ_W] = 8'($urandom);
            end
            if (k % 4 == 0) begin pb = pa; rb = ra; end
            load_cfg("R2 R3 rnd cfg");
            for (int i = 0; i < 8; i++) do_req(rnd_addr(), "R8 R9 rnd map");
        end
        finish_up();
    end
endmodule